// File: doc/BRIEF.md
# Activation Bit-Column Transposer

This block sits between the activation buffer and the rows of a weight-stationary systolic multiply array whose processing elements take their activations one bit at a time. It takes one word holding several two's-complement activations in parallel, one lane per array row. It then sends them out as bit columns. Each column holds the bits of equal significance from all lanes. The sign bit comes first and the least significant bit comes last. Each row's stream is delayed by one cycle more than the row above it, which gives the diagonal wavefront that the array's schedule expects.

The activation width is chosen per word. In narrow mode a word takes eight cycles and in wide mode it takes sixteen. Alongside the row-0 stream the block gives three flags: a valid flag, a marker for the sign-bit column, and a flag that is set when every lane's bit in the current column is zero. The array can use the last of these to skip that column. The input uses a valid/ready handshake. The next word is taken during the cycle that issues the final bit of the current word, so a stream of words runs without bubbles.

Top module: `act_transposer`

## Requirements
- R1: While reset is asserted, in_ready_o is 1, and ser_bits_o, col_valid_o, col_msb_o and col_zero_o are all 0.
- R2: in_ready_o is 0 while a word still has bits to issue after the current cycle. It is 1 when the block is idle and during the cycle that issues a word's last bit. A word is taken on a rising edge where in_valid_i and in_ready_o are both 1.
- R3: Take a word accepted at edge A in mode width W. In the cycle after A, row 0 outputs bit W-1 of lane 0. The following cycles step down one bit position each until bit 0, and col_valid_o is 1 for exactly those W cycles.
- R4: col_msb_o is 1 only in the cycle that row 0 carries the sign bit (bit W-1) of a word.
- R5: prec_wide_i = 1 selects W = 16 and prec_wide_i = 0 selects W = 8. The mode is sampled at acceptance and holds for the whole word.
- R6: Row r outputs the same bit sequence as row 0's timing would give for lane r, delayed by r cycles. Lane r occupies in_data_i bits [16r+15:16r].
- R7: col_zero_o is 1 in a cycle exactly when col_valid_o is 1 and the bits of all lanes at the bit position row 0 carries in that cycle are zero.
- R8: A row whose delayed stream carries no word bit outputs 0.
- R9: A word accepted during the last-bit cycle of the previous word starts on the very next cycle, with col_valid_o staying high and col_msb_o set.
- R10: In narrow mode, lane bits 15..8 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid_i | input | 1 | A parallel activation word is offered |
| in_ready_o | output | 1 | The block will take a word at the next edge |
| in_data_i | input | ROWS*16 | One 16-bit lane per row; narrow mode uses bits 7..0 of each lane |
| prec_wide_i | input | 1 | 1 selects 16-bit activations, 0 selects 8-bit |
| ser_bits_o | output | ROWS | Skewed serial bit per row, sign bit first |
| col_valid_o | output | 1 | Row 0 carries a word bit this cycle |
| col_msb_o | output | 1 | Row 0 carries the sign bit this cycle |
| col_zero_o | output | 1 | All lanes are zero at row 0's current bit position |

## Verification
Take a word accepted at edge A. Bit k of it, counted from the sign bit, is due on row r at the sample that follows edge A+k+r. The row-0 flags share that timing with r = 0. in_ready_o falls in the cycle after acceptance and comes back at A+W-1. The driver records the acceptance edge through the cycle counter. From it the driver queues one expected column per bit, each with its due cycle. The monitor samples every cycle 3 ns after the rising edge, before the driver changes any input. It takes the column whose due cycle has arrived and shifts it through its own per-row delay history. It compares every row, flag and the ready output against that history, and expects zero wherever no column is due.

// File: rtl/act_txp_pkg.sv
package act_txp_pkg;
  localparam int unsigned LANE_W   = 16;
  localparam int unsigned NARROW_W = 8;
  localparam int unsigned IDX_W    = $clog2(LANE_W);

  typedef enum logic {
    PREC_NARROW = 1'b0,
    PREC_WIDE   = 1'b1
  } prec_e;

  typedef logic [IDX_W-1:0] bit_idx_t;

  localparam bit_idx_t TOP_WIDE   = bit_idx_t'(LANE_W - 1);
  localparam bit_idx_t TOP_NARROW = bit_idx_t'(NARROW_W - 1);
endpackage

// File: rtl/act_txp_rst_sync.sv
module act_txp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d[0] = 1'b1;
    for (int k = 1; k < STAGES; k++) sync_d[k] = sync_q[k-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/act_txp_serializer.sv
module act_txp_serializer
  import act_txp_pkg::*;
#(
  parameter int unsigned ROWS = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  output logic                   in_ready_o,
  input  logic [ROWS*LANE_W-1:0] in_data_i,
  input  logic                   prec_wide_i,
  output logic [ROWS-1:0]        col_o,
  output logic                   valid_o,
  output logic                   msb_o,
  output logic                   zero_o
);
  logic     busy_q, busy_d;
  bit_idx_t idx_q, idx_d;
  prec_e    prec_q, prec_d;
  logic     accept;
  logic [LANE_W-1:0] lanes_q [ROWS];

  assign in_ready_o = !busy_q || (idx_q == '0);
  assign accept     = in_valid_i && in_ready_o;

  // next-state process
  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    prec_d = prec_q;
    if (accept) begin
      busy_d = 1'b1;
      prec_d = prec_e'(prec_wide_i);
      idx_d  = prec_wide_i ? TOP_WIDE : TOP_NARROW;
    end else if (busy_q) begin
      if (idx_q == '0) busy_d = 1'b0;
      else             idx_d  = idx_q - 1'b1;
    end
  end

  // control registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      prec_q <= PREC_NARROW;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      prec_q <= prec_d;
    end
  end

  // word holding registers, loaded on acceptance only
  for (genvar r = 0; r < ROWS; r++) begin : g_lane
    always_ff @(posedge clk_i) begin
      if (accept) lanes_q[r] <= in_data_i[r*LANE_W +: LANE_W];
    end
    assign col_o[r] = busy_q && lanes_q[r][idx_q];
  end

  assign valid_o = busy_q;
  assign msb_o   = busy_q && (idx_q == ((prec_q == PREC_WIDE) ? TOP_WIDE : TOP_NARROW));
  assign zero_o  = busy_q && (col_o == '0);
endmodule

// File: rtl/act_txp_delay.sv
module act_txp_delay #(
  parameter int unsigned DEPTH = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic dout_o
);
  logic [DEPTH-1:0] sr_q;
  logic [DEPTH-1:0] sr_d;

  always_comb begin
    sr_d[0] = din_i;
    for (int k = 1; k < DEPTH; k++) sr_d[k] = sr_q[k-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign dout_o = sr_q[DEPTH-1];
endmodule

// File: rtl/act_transposer.sv
module act_transposer
  import act_txp_pkg::*;
#(
  parameter int unsigned ROWS = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  output logic                   in_ready_o,
  input  logic [ROWS*LANE_W-1:0] in_data_i,
  input  logic                   prec_wide_i,
  output logic [ROWS-1:0]        ser_bits_o,
  output logic                   col_valid_o,
  output logic                   col_msb_o,
  output logic                   col_zero_o
);
  logic            rst_core_n;
  logic [ROWS-1:0] col_bits;

  act_txp_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_core_n)
  );

  act_txp_serializer #(.ROWS(ROWS)) u_ser (
    .clk_i       (clk_i),
    .rst_ni      (rst_core_n),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_data_i   (in_data_i),
    .prec_wide_i (prec_wide_i),
    .col_o       (col_bits),
    .valid_o     (col_valid_o),
    .msb_o       (col_msb_o),
    .zero_o      (col_zero_o)
  );

  // diagonal skew: row r sees its bit r cycles later
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    if (r == 0) begin : g_direct
      assign ser_bits_o[r] = col_bits[r];
    end else begin : g_delayed
      act_txp_delay #(.DEPTH(r)) u_dly (
        .clk_i  (clk_i),
        .rst_ni (rst_core_n),
        .din_i  (col_bits[r]),
        .dout_o (ser_bits_o[r])
      );
    end
  end
endmodule

// File: rtl/act_transposer_chk.sv
module act_transposer_chk #(
  parameter int unsigned ROWS = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic            in_ready_o,
  input logic [ROWS-1:0] ser_bits_o,
  input logic            col_valid_o,
  input logic            col_msb_o,
  input logic            col_zero_o,
  input logic [ROWS-1:0] col_bits
);
  AST_BUSY_WHEN_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> col_valid_o); // R2

  AST_IDLE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_valid_o && in_ready_o && !in_valid_i) |=> !col_valid_o); // R2

  AST_START_WITH_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(col_valid_o) |-> col_msb_o); // R4

  AST_SIGN_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_msb_o |-> col_valid_o); // R4

  AST_ZERO_COLUMN_ROW0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_zero_o |-> (col_valid_o && !ser_bits_o[0])); // R7

  AST_IDLE_ROW0_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !col_valid_o |-> !ser_bits_o[0]); // R8

  AST_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_valid_o && in_ready_o && in_valid_i) |=> (col_valid_o && col_msb_o)); // R9

  if (ROWS > 1) begin : g_skew
    AST_ROW1_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ser_bits_o[1] == $past(col_bits[1])); // R6
  end
endmodule

bind act_transposer act_transposer_chk #(.ROWS(ROWS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .ser_bits_o  (ser_bits_o),
  .col_valid_o (col_valid_o),
  .col_msb_o   (col_msb_o),
  .col_zero_o  (col_zero_o),
  .col_bits    (col_bits)
);

// File: tb/act_transposer_bench.sv
`timescale 1ns/1ps
module act_transposer_bench;
  localparam int ROWS = 4;
  localparam int LW   = 16;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 in_valid;
  logic                 in_ready;
  logic [ROWS*LW-1:0]   in_data;
  logic                 prec_wide;
  logic [ROWS-1:0]      ser_bits;
  logic                 col_valid, col_msb, col_zero;

  always #4 clk = ~clk;

  act_transposer #(.ROWS(ROWS)) u_act_transposer (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_data_i   (in_data),
    .prec_wide_i (prec_wide),
    .ser_bits_o  (ser_bits),
    .col_valid_o (col_valid),
    .col_msb_o   (col_msb),
    .col_zero_o  (col_zero)
  );

  typedef struct {
    int              t;
    logic [ROWS-1:0] col;
    logic            m;
    logic            z;
    int              tag;
  } exp_t;

  exp_t            q[$];
  logic [ROWS-1:0] hist [ROWS];
  int  cyc = 0;
  int  exp_last = 0;
  int  total = 0;
  int  bad = 0;
  bit  mon_en = 1'b0;
  bit  done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input int tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d %s at cycle %0d: actual=%0h expected=%0h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // driver: offers a word, records the accepting edge, queues expected columns
  task automatic send(input logic [ROWS*LW-1:0] d, input logic wide, input int tag);
    int a, w;
    @(negedge clk);
    in_valid  = 1'b1;
    in_data   = d;
    prec_wide = wide;
    while (!in_ready) @(negedge clk);
    a = cyc + 1;
    w = wide ? 16 : 8;
    for (int k = 0; k < w; k++) begin
      exp_t it;
      it.t = a + k;
      for (int r = 0; r < ROWS; r++) it.col[r] = d[r*LW + (w-1-k)];
      it.m   = (k == 0);
      it.z   = (it.col == '0);
      it.tag = tag;
      q.push_back(it);
    end
    exp_last = a + w - 1;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // monitor: samples 3 ns after each rising edge
  initial begin
    for (int r = 0; r < ROWS; r++) hist[r] = '0;
    forever begin
      @(posedge clk);
      #3;
      if (mon_en) begin
        logic [ROWS-1:0] col_e;
        bit   ev, me, ze;
        int   tg;
        ev = 1'b0; me = 1'b0; ze = 1'b0; col_e = '0; tg = 8;
        if (q.size() > 0 && q[0].t == cyc) begin
          exp_t it;
          it = q.pop_front();
          ev = 1'b1; me = it.m; ze = it.z; col_e = it.col; tg = it.tag;
        end
        for (int r = ROWS-1; r > 0; r--) hist[r] = hist[r-1];
        hist[0] = col_e;
        for (int r = 0; r < ROWS; r++) begin
          // R3 covers row 0, R6 the delayed rows, R8 idle rows
          check(ser_bits[r] == hist[r][r], (r == 0) ? 3 : 6,
                $sformatf("row%0d bit (word tag R%0d)", r, tg), ser_bits[r], hist[r][r]);
        end
        if (!ev) check(ser_bits[0] == 1'b0, 8, "idle row0", ser_bits[0], 0);
        check(col_valid == ev, 3, "col_valid", col_valid, ev);
        check(col_msb == me, 4, "col_msb", col_msb, me);
        check(col_zero == ze, 7, "col_zero", col_zero, ze);
        check(in_ready == (cyc >= exp_last), 2, "in_ready", in_ready, (cyc >= exp_last));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired at cycle %0d: actual=running expected=done", cyc);
    finish_up();
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    prec_wide = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(in_ready == 1'b1, 1, "reset in_ready", in_ready, 1);
    check(ser_bits == '0, 1, "reset ser_bits", ser_bits, 0);
    check({col_valid, col_msb, col_zero} == 3'b000, 1, "reset flags",
          {col_valid, col_msb, col_zero}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1'b1;

    // R3 narrow signed mix
    send({16'h0081, 16'h007F, 16'h0000, 16'h00FF}, 1'b0, 3);
    repeat (6) @(negedge clk);
    // R10 narrow with junk in the upper lane bits
    send({16'hAB05, 16'hCD03, 16'hEF01, 16'h1200}, 1'b0, 10);
    repeat (5) @(negedge clk);
    // R5 wide words
    send({16'h8001, 16'h7FFE, 16'h1234, 16'hFFFF}, 1'b1, 5);
    send({16'hC3A5, 16'h0F0F, 16'h8000, 16'h7FFF}, 1'b1, 5);
    repeat (4) @(negedge clk);
    // R7 words with many zero columns
    send({16'h0003, 16'h0001, 16'h0002, 16'h0000}, 1'b1, 7);
    send({16'hFF00, 16'h0000, 16'h5500, 16'h0000}, 1'b0, 7);
    repeat (7) @(negedge clk);
    // R9 gapless stream with mixed widths
    for (int i = 0; i < 12; i++) begin
      logic [ROWS*LW-1:0] d;
      for (int r = 0; r < ROWS; r++)
        d[r*LW +: LW] = 16'(((i + 1) * 16'h1357) ^ (r * 16'h2C49) ^ (i << r));
      send(d, (i % 3) == 0, 9);
    end
    repeat (24) @(negedge clk);
    check(q.size() == 0, 3, "columns left in scoreboard", q.size(), 0);
    finish_up();
  end
endmodule